// File: doc/BRIEF.md
# AXI Burst Beat Address Generator

This unit sits inside an AXI4 subordinate and works out the byte address of every beat of a burst, so that the manager only has to send the first address. A load strobe captures the start address, the beat count field, the transfer size field and the burst mode. Each advance strobe then steps the address to the next beat. Alongside the address the unit gives a last-beat flag and the byte lanes that the beat occupies on a data bus of parameterized width.

Three burst modes are handled: a repeating address, an incrementing address, and an incrementing address that folds back inside a window whose size is the burst length times the transfer size. At load time the request is also checked, and error flags report an illegal wrap length, a wrap start that is not aligned to the transfer size, or an incrementing burst that would leave its 4 KB page. The handshakes, the data path and the response logic belong to the surrounding subordinate.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, and until the first load, addr_o is 0, last_o is 0, lane_mask is 0 and all three error flags are 0; advance has no effect before the first load.
- R2: In the cycle after load is high, addr_o equals the captured start_addr, the beat counter restarts at zero and last_o is 1 exactly when len is 0.
- R3: With burst code 0 (fixed) or the unused code 3, each accepted advance leaves addr_o and lane_mask unchanged.
- R4: With burst code 1 (incrementing), each accepted advance sets addr_o to addr_o rounded down to a multiple of 2^size, plus 2^size.
- R5: With burst code 2 (wrapping) and a legal request, each advance adds 2^size, and an address that reaches the top of the window returns to its base; the window is (len+1)·2^size bytes and its base is the start address rounded down to a multiple of that.
- R6: The burst has len+1 beats: last_o rises in the cycle after the len-th accepted advance following a load.
- R7: An advance while last_o is high is ignored: addr_o, lane_mask and last_o keep their values.
- R8: Bit i of lane_mask is 1 exactly when o ≤ i < (o rounded down to a multiple of 2^size) + 2^size, where o is addr_o modulo DATA_BYTES; an unaligned first beat therefore covers only the lanes from its start byte to the next size boundary.
- R9: err_wrap_len is 1 after a load with burst code 2 whose len is not 1, 3, 7 or 15; such a burst then steps as in R4.
- R10: err_wrap_align is 1 after a load with burst code 2 whose start_addr is not a multiple of 2^size; such a burst then steps as in R4.
- R11: err_4k is 1 after a load with burst code 1 when (start_addr mod 4096, rounded down to a multiple of 2^size) + (len+1)·2^size exceeds 4096; all error flags hold until the next load and are 0 for the other cases.
- R12: When load and advance are high in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture a new burst request |
| start_addr | input | ADDR_W | First byte address of the burst |
| len | input | 8 | Beat count minus one |
| size | input | 3 | Bytes per beat as a power of two |
| burst | input | 2 | Mode: 0 fixed, 1 incrementing, 2 wrapping |
| advance | input | 1 | Step to the next beat |
| addr_o | output | ADDR_W | Byte address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| lane_mask | output | DATA_BYTES | Byte lanes used by the current beat |
| err_wrap_len | output | 1 | Wrap request with an illegal beat count |
| err_wrap_align | output | 1 | Wrap request with an unaligned start |
| err_4k | output | 1 | Incrementing request leaves its 4 KB page |

## Verification
Every output is a register, so each result belongs to the single clock edge that follows the load or advance that caused it: address, lane mask, last flag and error flags after a load, and the next address, mask and last flag after an advance. The bench raises each strobe just after a falling edge, lowers it at the next falling edge, and compares the outputs at that same falling edge, one full edge after the stimulus and half a period away from any change. Bursts are walked beat by beat, so the final address and the rise of the last flag are checked at the exact advance count len.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam logic [1:0] MODE_FIXED = 2'd0;
  localparam logic [1:0] MODE_INCR  = 2'd1;
  localparam logic [1:0] MODE_WRAP  = 2'd2;
  localparam int         PAGE_BYTES = 4096;
  localparam int         WIN_W      = 12;
endpackage

// File: rtl/bag_request_check.sv
module bag_request_check
  import burst_pkg::*;
(
  input  logic [WIN_W-1:0] page_off,
  input  logic [7:0]       len,
  input  logic [2:0]       size,
  input  logic [1:0]       burst,
  output logic             bad_len,
  output logic             bad_align,
  output logic             over_page,
  output logic [1:0]       eff_mode,
  output logic [WIN_W-1:0] win_mask
);
  logic [7:0]       size_lsbs;
  logic [WIN_W-1:0] aligned_off;
  logic [15:0]      total;
  logic [16:0]      reach;
  logic             legal_count;

  always_comb begin
    size_lsbs   = (8'd1 << size) - 8'd1;
    aligned_off = page_off & ~{{(WIN_W-8){1'b0}}, size_lsbs};
    total       = ({8'd0, len} + 16'd1) << size;
    reach       = {5'd0, aligned_off} + {1'b0, total};
    legal_count = (len == 8'd1) || (len == 8'd3) || (len == 8'd7) || (len == 8'd15);
    bad_len     = (burst == MODE_WRAP) && !legal_count;
    bad_align   = (burst == MODE_WRAP) && ((page_off[7:0] & size_lsbs) != 8'd0);
    over_page   = (burst == MODE_INCR) && (reach > 17'(PAGE_BYTES));
    win_mask    = ({{(WIN_W-4){1'b0}}, len[3:0]} + 12'd1) << size;
    win_mask    = win_mask - 12'd1;
    if (burst == MODE_WRAP && !bad_len && !bad_align) eff_mode = MODE_WRAP;
    else if (burst == MODE_WRAP || burst == MODE_INCR) eff_mode = MODE_INCR;
    else eff_mode = MODE_FIXED;
  end
endmodule

// File: rtl/bag_next_addr.sv
module bag_next_addr
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        size,
  input  logic [1:0]        mode,
  input  logic [WIN_W-1:0]  win_mask,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] wm;
  logic [ADDR_W-1:0] bumped;

  always_comb begin
    step   = {{(ADDR_W-1){1'b0}}, 1'b1} << size;
    wm     = {{(ADDR_W-WIN_W){1'b0}}, win_mask};
    bumped = (cur & ~(step - 1'b1)) + step;
    case (mode)
      MODE_INCR: nxt = bumped;
      MODE_WRAP: nxt = (cur & ~wm) | ((cur + step) & wm);
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/bag_lane_mask.sv
module bag_lane_mask #(
  parameter int DATA_BYTES = 8,
  localparam int LANE_W = $clog2(DATA_BYTES)
) (
  input  logic [LANE_W-1:0]     offs,
  input  logic [2:0]            size,
  output logic [DATA_BYTES-1:0] mask
);
  int lo_i;
  int hi_i;

  always_comb begin
    lo_i = int'(offs);
    hi_i = (lo_i & ~((1 << size) - 1)) + (1 << size);
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    assign mask[g] = (g >= lo_i) && (g < hi_i);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  localparam int LANE_W    = $clog2(DATA_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic [7:0]            len,
  input  logic [2:0]            size,
  input  logic [1:0]            burst,
  input  logic                  advance,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  last_o,
  output logic [DATA_BYTES-1:0] lane_mask,
  output logic                  err_wrap_len,
  output logic                  err_wrap_align,
  output logic                  err_4k
);
  logic [7:0]            cnt_q, len_q;
  logic [2:0]            size_q;
  logic [1:0]            mode_q;
  logic [WIN_W-1:0]      wm_q;
  logic                  valid_q;

  logic                  c_bad_len, c_bad_align, c_over;
  logic [1:0]            c_mode;
  logic [WIN_W-1:0]      c_wm;
  logic [ADDR_W-1:0]     nxt_addr, mask_src;
  logic [2:0]            mask_size;
  logic [DATA_BYTES-1:0] mask_c;
  logic                  step_ok;

  bag_request_check u_check (
    .page_off (start_addr[WIN_W-1:0]),
    .len      (len),
    .size     (size),
    .burst    (burst),
    .bad_len  (c_bad_len),
    .bad_align(c_bad_align),
    .over_page(c_over),
    .eff_mode (c_mode),
    .win_mask (c_wm)
  );

  bag_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .cur     (addr_o),
    .size    (size_q),
    .mode    (mode_q),
    .win_mask(wm_q),
    .nxt     (nxt_addr)
  );

  assign mask_src  = load ? start_addr : nxt_addr;
  assign mask_size = load ? size : size_q;

  bag_lane_mask #(.DATA_BYTES(DATA_BYTES)) u_mask (
    .offs(mask_src[LANE_W-1:0]),
    .size(mask_size),
    .mask(mask_c)
  );

  assign step_ok = advance && valid_q && !last_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o         <= '0;
      last_o         <= 1'b0;
      lane_mask      <= '0;
      err_wrap_len   <= 1'b0;
      err_wrap_align <= 1'b0;
      err_4k         <= 1'b0;
      cnt_q          <= '0;
      len_q          <= '0;
      size_q         <= '0;
      mode_q         <= MODE_FIXED;
      wm_q           <= '0;
      valid_q        <= 1'b0;
    end else if (load) begin
      addr_o         <= start_addr;
      last_o         <= (len == 8'd0);
      lane_mask      <= mask_c;
      err_wrap_len   <= c_bad_len;
      err_wrap_align <= c_bad_align;
      err_4k         <= c_over;
      cnt_q          <= '0;
      len_q          <= len;
      size_q         <= size;
      mode_q         <= c_mode;
      wm_q           <= c_wm;
      valid_q        <= 1'b1;
    end else if (step_ok) begin
      addr_o    <= nxt_addr;
      lane_mask <= mask_c;
      cnt_q     <= cnt_q + 8'd1;
      last_o    <= (cnt_q + 8'd1 == len_q);
    end
  end

  // R1: clean outputs once reset is released
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (addr_o == '0 && !last_o && lane_mask == '0 && !err_4k));

  // R2 and R12: a load defines the next address whatever advance does
  a_r12_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> addr_o == $past(start_addr));

  // R2 and R6: a zero-length burst is last at once
  a_r6_len_zero_last: assert property (@(posedge clk) disable iff (rst)
    load |=> last_o == ($past(len) == 8'd0));

  // R7: nothing moves after the final beat
  a_r7_hold_after_last: assert property (@(posedge clk) disable iff (rst)
    (last_o && advance && !load) |=> ($stable(addr_o) && last_o && $stable(lane_mask)));

  // R3: fixed mode repeats the address
  a_r3_fixed_repeat: assert property (@(posedge clk) disable iff (rst)
    (valid_q && mode_q == MODE_FIXED && advance && !load) |=> $stable(addr_o));

  // R5: a wrapping step never leaves its window
  a_r5_wrap_window: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_WRAP && step_ok && !load) |=>
      ((addr_o & ~{{(ADDR_W-WIN_W){1'b0}}, wm_q}) ==
       ($past(addr_o) & ~{{(ADDR_W-WIN_W){1'b0}}, wm_q})));

  // R8: a loaded burst always drives at least one lane
  a_r8_lane_present: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> lane_mask != '0);
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 32;
  localparam int DB = 8;

  typedef struct packed {
    logic [1:0]  burst;
    logic [2:0]  size;
    logic [7:0]  len;
    logic [31:0] start;
    logic [31:0] a1;
    logic [31:0] fin;
    logic [7:0]  m0;
    logic [2:0]  errs;   // {wrap_len, wrap_align, 4k}
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'd2, 8'd3,  32'h1004, 32'h1008, 32'h1010, 8'hF0, 3'b000},
    '{2'd1, 3'd2, 8'd3,  32'h1006, 32'h1008, 32'h1010, 8'hC0, 3'b000},
    '{2'd0, 3'd1, 8'd2,  32'h2003, 32'h2003, 32'h2003, 8'h08, 3'b000},
    '{2'd2, 3'd2, 8'd3,  32'h3008, 32'h300C, 32'h3004, 8'h0F, 3'b000},
    '{2'd2, 3'd3, 8'd1,  32'h4008, 32'h4000, 32'h4000, 8'hFF, 3'b000},
    '{2'd1, 3'd3, 8'd3,  32'h0FF0, 32'h0FF8, 32'h1008, 8'hFF, 3'b001},
    '{2'd2, 3'd2, 8'd2,  32'h5000, 32'h5004, 32'h5008, 8'h0F, 3'b100},
    '{2'd2, 3'd2, 8'd3,  32'h6002, 32'h6004, 32'h600C, 8'h0C, 3'b010},
    '{2'd1, 3'd0, 8'd0,  32'h7005, 32'h7005, 32'h7005, 8'h20, 3'b000},
    '{2'd1, 3'd2, 8'd3,  32'h1FF0, 32'h1FF4, 32'h1FFC, 8'h0F, 3'b000},
    '{2'd2, 3'd0, 8'd15, 32'h8013, 32'h8014, 32'h8012, 8'h08, 3'b000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0]    len = '0;
  logic [2:0]    size = '0;
  logic [1:0]    burst = '0;
  logic          advance = 1'b0;
  logic [AW-1:0] addr_o;
  logic          last_o;
  logic [DB-1:0] lane_mask;
  logic          err_wrap_len, err_wrap_align, err_4k;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .DATA_BYTES(DB)) u_dut (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr), .len(len),
    .size(size), .burst(burst), .advance(advance), .addr_o(addr_o),
    .last_o(last_o), .lane_mask(lane_mask), .err_wrap_len(err_wrap_len),
    .err_wrap_align(err_wrap_align), .err_4k(err_4k)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] b, input logic [2:0] s,
                         input logic [7:0] l, input logic [31:0] a, input logic adv);
    burst = b; size = s; len = l; start_addr = a; load = 1'b1; advance = adv;
    @(negedge clk);
    load = 1'b0; advance = 1'b0;
  endtask

  task automatic step();
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values, and advance before any load does nothing
    chk("R1 addr", 64'(addr_o), 64'h0);
    chk("R1 last", 64'(last_o), 64'h0);
    chk("R1 mask", 64'(lane_mask), 64'h0);
    chk("R1 errs", 64'({err_wrap_len, err_wrap_align, err_4k}), 64'h0);
    step();
    chk("R1 advance before load", 64'(addr_o), 64'h0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      string mtag;
      v = VECS[k];
      mtag = (v.burst == 2'd0) ? "R3" : (v.burst == 2'd1) ? "R4" : "R5";
      do_load(v.burst, v.size, v.len, v.start, 1'b0);
      chk("R2 start", 64'(addr_o), 64'(v.start));
      chk("R8 first lanes", 64'(lane_mask), 64'(v.m0));
      chk("R9 R10 R11 errors", 64'({err_wrap_len, err_wrap_align, err_4k}), 64'(v.errs));
      chk("R6 last at load", 64'(last_o), 64'(v.len == 8'd0));
      if (v.len >= 8'd1) begin
        step();
        chk({mtag, " second beat"}, 64'(addr_o), 64'(v.a1));
        for (int j = 1; j < int'(v.len); j++) begin
          chk("R6 not last early", 64'(last_o), 64'h0);
          step();
        end
        chk({mtag, " final beat"}, 64'(addr_o), 64'(v.fin));
        chk("R6 last on final", 64'(last_o), 64'h1);
        chk("R11 errors held", 64'({err_wrap_len, err_wrap_align, err_4k}), 64'(v.errs));
      end
      step();
      chk("R7 addr after last", 64'(addr_o), 64'(v.fin));
      chk("R7 last held", 64'(last_o), 64'h1);
    end

    // R8: aligned beat after an unaligned start uses the full size window
    do_load(2'd1, 3'd2, 8'd3, 32'h1006, 1'b0);
    step();
    chk("R8 aligned lanes", 64'(lane_mask), 64'h0F);
    // R3: fixed burst keeps the same lanes
    do_load(2'd0, 3'd1, 8'd2, 32'h2003, 1'b0);
    step();
    chk("R3 fixed lanes", 64'(lane_mask), 64'h08);

    // R12: load and advance together mid-burst
    do_load(2'd1, 3'd2, 8'd7, 32'h0100, 1'b0);
    step();
    step();
    do_load(2'd1, 3'd3, 8'd1, 32'h9000, 1'b1);
    chk("R12 load wins addr", 64'(addr_o), 64'h9000);
    chk("R12 load wins last", 64'(last_o), 64'h0);

    // R1: reset in the middle of a burst
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-burst reset addr", 64'(addr_o), 64'h0);
    chk("R1 mid-burst reset mask", 64'(lane_mask), 64'h0);
    finish_run();
  end
endmodule